// File: doc/BRIEF.md
# Pipelined Signed Integer Divider

This block divides a two's-complement dividend by an unsigned divisor of half its width. It is fully pipelined. On every clock where the enable is high it takes in a new operand pair. A fixed number of enabled clocks later it presents the truncated quotient and the matching remainder. Both results are signed and one bit wider than the divisor.

Two flags come out in the same cycle as the results they belong to. One marks a zero divisor. The other marks a quotient too large for the result width. When either flag is high, the quotient and remainder carry no meaning.

Inside, the block first takes the magnitude of the dividend. It then runs one restoring subtract-and-shift stage for each quotient bit. A final stage puts the sign back and decides the flags. Dropping the enable freezes every stage, so a stalled stream picks up again without losing or repeating any operation.

Top module: `sdiv_pipe`

## Requirements
- R1: While `rst_n` is low, every pipeline stage is cleared and `quo`, `rem`, `dz` and `ovf` read zero. Slots emptied by reset hold a zero divisor, so they come out with `dz` high as valid data flows in behind them.
- R2: When `dvs` is non-zero and no overflow occurs, `quo` equals `dvd / dvs` truncated toward zero, as a 9-bit two's-complement value. `dvd` is 16-bit two's complement and `dvs` is an 8-bit unsigned magnitude from 0 to 255. The sign of a non-zero quotient follows the dividend.
- R3: In the same case, `rem` equals `dvd - dvs*quo` as a 9-bit two's-complement value. Its magnitude is below `dvs` and its sign follows the dividend.
- R4: An operation with `dvs` equal to 0 reports `dz` high and `ovf` low.
- R5: An operation with a non-zero `dvs` whose true quotient falls outside -256..255 reports `ovf` high and `dz` low.
- R6: The result of an operand pair applied with `en` high before clock edge k appears after edge k+10. The latency is the divisor width plus 3 enabled cycles. A new pair can enter on every clock.
- R7: While `en` is low, all outputs keep their values and the operand inputs are ignored. When `en` returns high, the stream continues with no operation lost or duplicated.
- R8: The extreme operands are handled exactly. For example, -32768/128 gives -256 remainder 0, 32767/128 gives 255 remainder 127, and -32768/127 reports overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Advances all stages when high |
| dvd | input | 16 | Dividend, two's complement |
| dvs | input | 8 | Divisor, unsigned magnitude |
| quo | output | 9 | Quotient, two's complement |
| rem | output | 9 | Remainder, two's complement |
| dz | output | 1 | Divide-by-zero flag for this result |
| ovf | output | 1 | Quotient-overflow flag for this result |

## Verification
The hardest cases to reach are the narrow bands at the overflow limit. A quotient of exactly -256 is legal, while +256 and -257 are not. The most negative dividend sits where its magnitude has no positive two's-complement form. A plain random sweep rarely hits any of these, so directed pairs such as ±256/1, -257/1, -32768/128 and 32767/128 are placed next to each other in one back-to-back stream. A stride sweep across the whole dividend range, paired with divisors at 1, 127, 128 and 255, adds coverage on top. A stall is also placed in the middle of a full pipeline. During the stall the operand inputs carry a zero divisor that would show up as a `dz` if it were wrongly taken in.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
    // Side information that travels with each operation.
    typedef struct packed {
        logic neg;   // dividend was negative
        logic big;   // quotient cannot fit the magnitude field
    } tag_t;
endpackage

// File: rtl/sdiv_prep.sv
module sdiv_prep
    import sdiv_pkg::*;
#(
    parameter int ZW = 16,
    parameter int DW = ZW / 2
) (
    input  logic [ZW-1:0] dvd,
    input  logic [DW-1:0] dvs,
    output logic [DW-1:0] hi,
    output logic [DW:0]   lo,
    output tag_t          tag
);
    logic [ZW-1:0] mag;
    logic [ZW-1:0] upper;

    always_comb begin
        mag     = dvd[ZW-1] ? (~dvd + 1'b1) : dvd;
        upper   = mag >> (DW + 1);
        hi      = DW'(upper);
        lo      = mag[DW:0];
        tag.neg = dvd[ZW-1];
        // If the bits above the quotient field reach the divisor,
        // the magnitude of the quotient needs more than DW+1 bits.
        tag.big = upper >= ZW'(dvs);
    end
endmodule

// File: rtl/sdiv_step.sv
module sdiv_step #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] rem_i,
    input  logic [DW:0]   lo_i,
    input  logic [DW-1:0] den_i,
    output logic [DW-1:0] rem_o,
    output logic [DW:0]   lo_o
);
    logic [DW:0] trial;
    logic        fits;

    always_comb begin
        trial = {rem_i, lo_i[DW]};
        fits  = trial >= {1'b0, den_i};
        rem_o = DW'(fits ? trial - {1'b0, den_i} : trial);
        // The low field shifts out dividend bits and takes in quotient bits.
        lo_o  = {lo_i[DW-1:0], fits};
    end
endmodule

// File: rtl/sdiv_fix.sv
module sdiv_fix
    import sdiv_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW:0]   qmag,
    input  logic [DW-1:0] rmag,
    input  logic [DW-1:0] den,
    input  tag_t          tag,
    output logic [DW:0]   q,
    output logic [DW:0]   r,
    output logic          dz,
    output logic          ov
);
    logic range_bad;

    always_comb begin
        // A negative result may reach 2**DW, a positive one only 2**DW-1.
        range_bad = tag.neg ? (qmag[DW] && (|qmag[DW-1:0])) : qmag[DW];
        dz        = den == '0;
        ov        = !dz && (tag.big || range_bad);
        q         = tag.neg ? (~qmag + 1'b1) : qmag;
        r         = tag.neg ? (~{1'b0, rmag} + 1'b1) : {1'b0, rmag};
    end
endmodule

// File: rtl/sdiv_pipe.sv
module sdiv_pipe
    import sdiv_pkg::*;
#(
    parameter int ZW = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en,
    input  logic [ZW-1:0]          dvd,
    input  logic [ZW/2-1:0]        dvs,
    output logic [ZW/2:0]          quo,
    output logic [ZW/2:0]          rem,
    output logic                   dz,
    output logic                   ovf
);
    localparam int DW    = ZW / 2;
    localparam int NSTEP = DW + 1;
    localparam int LAT   = NSTEP + 2;

    typedef struct packed {
        logic [DW-1:0] rem;
        logic [DW:0]   lo;
        logic [DW-1:0] den;
        tag_t          tag;
    } stg_t;

    typedef struct packed {
        logic [DW:0] q;
        logic [DW:0] r;
        logic        dz;
        logic        ov;
    } out_t;

    typedef struct packed {
        stg_t [NSTEP:0] s;
        out_t           o;
    } state_t;

    state_t state_d, state_q;

    logic [DW-1:0] pre_hi;
    logic [DW:0]   pre_lo;
    tag_t          pre_tag;

    logic [DW-1:0] st_rem [NSTEP];
    logic [DW:0]   st_lo  [NSTEP];

    logic [DW:0]   fx_q, fx_r;
    logic          fx_dz, fx_ov;

    sdiv_prep #(.ZW(ZW), .DW(DW)) u_prep (
        .dvd (dvd),
        .dvs (dvs),
        .hi  (pre_hi),
        .lo  (pre_lo),
        .tag (pre_tag)
    );

    for (genvar k = 0; k < NSTEP; k++) begin : g_step
        sdiv_step #(.DW(DW)) u_step (
            .rem_i (state_q.s[k].rem),
            .lo_i  (state_q.s[k].lo),
            .den_i (state_q.s[k].den),
            .rem_o (st_rem[k]),
            .lo_o  (st_lo[k])
        );
    end

    sdiv_fix #(.DW(DW)) u_fix (
        .qmag (state_q.s[NSTEP].lo),
        .rmag (state_q.s[NSTEP].rem),
        .den  (state_q.s[NSTEP].den),
        .tag  (state_q.s[NSTEP].tag),
        .q    (fx_q),
        .r    (fx_r),
        .dz   (fx_dz),
        .ov   (fx_ov)
    );

    always_comb begin
        state_d = state_q;
        if (en) begin
            state_d.s[0].rem = pre_hi;
            state_d.s[0].lo  = pre_lo;
            state_d.s[0].den = dvs;
            state_d.s[0].tag = pre_tag;
            for (int k = 0; k < NSTEP; k++) begin
                state_d.s[k+1].rem = st_rem[k];
                state_d.s[k+1].lo  = st_lo[k];
                state_d.s[k+1].den = state_q.s[k].den;
                state_d.s[k+1].tag = state_q.s[k].tag;
            end
            state_d.o.q  = fx_q;
            state_d.o.r  = fx_r;
            state_d.o.dz = fx_dz;
            state_d.o.ov = fx_ov;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign quo = state_q.o.q;
    assign rem = state_q.o.r;
    assign dz  = state_q.o.dz;
    assign ovf = state_q.o.ov;

    initial begin
        if (LAT != DW + 3) $error("latency derivation broken");
    end
endmodule

// File: rtl/sdiv_pipe_chk.sv
module sdiv_pipe_chk #(
    parameter int DW  = 8,
    parameter int LAT = DW + 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic [DW-1:0] dvs,
    input logic [DW:0]   quo,
    input logic [DW:0]   rem,
    input logic          dz,
    input logic          ovf
);
    // Zero-divisor history: reset leaves the internal slots with a zero
    // divisor and the output slot clear.
    logic [LAT-1:0] zsh;

    always_ff @(posedge clk) begin
        if (!rst_n)  zsh <= {1'b0, {(LAT-1){1'b1}}};
        else if (en) zsh <= {zsh[LAT-2:0], dvs == '0};
    end

    p_div0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dz == zsh[LAT-1]);

    p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dz |-> !ovf);

    p_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!dz && !ovf && quo != '0 && rem != '0) |-> (quo[DW] == rem[DW]));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(quo) && $stable(rem) && $stable(dz) && $stable(ovf)));
endmodule

bind sdiv_pipe sdiv_pipe_chk #(.DW(DW), .LAT(LAT)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .dvs   (dvs),
    .quo   (quo),
    .rem   (rem),
    .dz    (dz),
    .ovf   (ovf)
);

// File: tb/sim_sdiv_pipe.sv
`timescale 1ns / 1ps
module sim_sdiv_pipe;
    localparam int ZW  = 16;
    localparam int DW  = ZW / 2;
    localparam int LAT = DW + 3;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 en = 1'b0;
    logic signed [ZW-1:0] dvd = '0;
    logic [DW-1:0]        dvs = '0;
    logic signed [DW:0]   quo, rem;
    logic                 dz, ovf;

    int checks = 0;
    int errors = 0;
    int oz[$];
    int od[$];

    sdiv_pipe #(.ZW(ZW)) u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .dvd(dvd), .dvs(dvs),
        .quo(quo), .rem(rem), .dz(dz), .ovf(ovf)
    );

    always #10 clk = ~clk;

    task automatic add(input int z, input int d);
        oz.push_back(z);
        od.push_back(d);
    endtask

    task automatic check_op(input int z, input int d, input string req);
        int  qt, rt;
        bit  ok;
        bit  edz, eov;
        qt = 0; rt = 0; edz = (d == 0); eov = 0;
        if (!edz) begin
            qt  = z / d;
            rt  = z - d * qt;
            eov = (qt > 255) || (qt < -256);
        end
        if (edz)      ok = dz && !ovf;
        else if (eov) ok = ovf && !dz;
        else          ok = !dz && !ovf && (int'(quo) == qt) && (int'(rem) == rt);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s z=%0d d=%0d got q=%0d r=%0d dz=%0b ov=%0b exp q=%0d r=%0d dz=%0b ov=%0b",
                     req, z, d, quo, rem, dz, ovf, qt, rt, edz, eov);
        end
    endtask

    // Streams the queued operations back to back, one per clock, and checks
    // each result exactly LAT edges after its operands were taken in.
    task automatic run(input string req, input int stall_at, input int stall_len);
        int n;
        n = oz.size();
        for (int i = 0; i < n + LAT; i++) begin
            @(negedge clk);
            if (i >= LAT) check_op(oz[i-LAT], od[i-LAT], req);
            if (i == stall_at) begin
                logic [DW:0] sq, sr;
                logic        sdz, sov;
                sq = quo; sr = rem; sdz = dz; sov = ovf;
                en  = 1'b0;
                dvd = 16'sh1234;
                dvs = '0;
                for (int s = 0; s < stall_len; s++) begin
                    @(negedge clk);
                    checks++;
                    if (quo !== sq || rem !== sr || dz !== sdz || ovf !== sov) begin
                        errors++;
                        $display("FAIL R7 stall hold got q=%0d r=%0d dz=%0b ov=%0b exp q=%0d r=%0d dz=%0b ov=%0b",
                                 quo, rem, dz, ovf, sq, sr, sdz, sov);
                    end
                end
            end
            en  = 1'b1;
            dvd = (i < n) ? ZW'(oz[i]) : '0;
            dvs = (i < n) ? DW'(od[i]) : DW'(1);
        end
        oz.delete();
        od.delete();
    endtask

    task automatic t_reset();
        en = 1'b1; dvd = -16'sd5; dvs = '0;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            checks++;
            if (quo !== '0 || rem !== '0 || dz !== 1'b0 || ovf !== 1'b0) begin
                errors++;
                $display("FAIL R1 reset got q=%0d r=%0d dz=%0b ov=%0b exp 0 0 0 0", quo, rem, dz, ovf);
            end
        end
        en = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (quo !== '0 || rem !== '0 || dz !== 1'b0 || ovf !== 1'b0) begin
            errors++;
            $display("FAIL R1 after release got q=%0d r=%0d dz=%0b ov=%0b exp 0 0 0 0", quo, rem, dz, ovf);
        end
    endtask

    task automatic t_basic();
        add(100, 7); add(17, 5); add(0, 9); add(255, 255); add(1000, 10);
        add(6, 7); add(250, 1); add(12345, 99);
        run("R2 R3 R6 basic", -1, 0);
    endtask

    task automatic t_signs();
        add(-100, 7); add(-17, 5); add(-6, 7); add(-1, 1); add(-12345, 99);
        add(-1000, 10); add(-3, 2); add(3, 2);
        run("R2 R3 signs", -1, 0);
    endtask

    task automatic t_bounds();
        add(255, 1); add(256, 1); add(-256, 1); add(-257, 1);
        add(-32768, 128); add(32767, 128); add(-32768, 127); add(-32768, 255);
        add(32767, 255); add(32767, 1); add(511, 2); add(512, 2);
        add(-513, 2); add(-514, 2);
        run("R5 R8 bounds", -1, 0);
    endtask

    task automatic t_div0();
        add(42, 0); add(-32768, 0); add(0, 0); add(50, 5); add(32767, 0);
        run("R4 div0", -1, 0);
    endtask

    task automatic t_stall();
        for (int k = 0; k < 20; k++) add(-5000 + 517 * k, 3 + 11 * k);
        run("R7 stall", 14, 5);
        for (int k = 0; k < 12; k++) add(3000 - 611 * k, 128 + k);
        run("R7 stall early", 3, 2);
    endtask

    task automatic t_sweep();
        int dl[6] = '{1, 3, 127, 128, 200, 255};
        for (int j = 0; j < 6; j++) begin
            for (int z = -32768; z < 32768; z += 251) add(z, dl[j]);
            add(32767, dl[j]);
            run("R2 R3 R5 R6 sweep", -1, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R6 watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_signs();
        t_bounds();
        t_div0();
        t_stall();
        t_sweep();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule